// File: doc/BRIEF.md
# Predicate File with Guarded Writeback

This block keeps the condition bits of a four-slot wide-issue datapath and uses them to decide, slot by slot, which side effects actually happen. A compare in any slot can set one of sixteen one-bit predicates. Any slot can name any predicate as its guard, in either its true or its false sense. The block turns each slot's raw register-write and store requests into guarded enables. It accepts a branch only from one fixed slot, and it also offers each slot a two-way select that picks one of two operands by a predicate's value.

The predicates live in flip-flops, each with its own enable. All four slots can read the file and write to it in the same cycle. Predicate 0 always reads as true, so an operation with no condition names it as its guard. A write lands at the next clock edge, so guards read in the same cycle still see the older value. When several slots write the same predicate in one cycle, the highest-numbered slot takes priority.

Top module: `pred_guard_unit`

## Requirements
- R1: While reset is asserted and just after it is released, pred_q reads 16'h0001: predicate 0 is true and every other predicate is false.
- R2: pred_q[0] is always 1, and a write that targets index 0 leaves it unchanged.
- R3: Slot s writes predicate pw_idx[4s+3:4s] with value pw_val[s] when pw_en[s] is high and its guard is true. The new value shows on pred_q after the next rising edge. Guards and selects evaluated in the same cycle use the value from before the write.
- R4: When two or more enabled slots with true guards target the same index in one cycle, the value from the highest-numbered slot is stored.
- R5: The guard of slot s is pred_q[g_idx[4s+3:4s]] XOR g_inv[s]. With g_inv[s]=1 the operation runs only when the named predicate is false.
- R6: rf_we[s] equals rf_we_raw[s] AND the guard of slot s, in the same cycle. A conditional move is therefore a register write that happens only when its predicate is true.
- R7: st_en[s] equals st_en_raw[s] AND the guard of slot s, in the same cycle.
- R8: br_take equals br_req[0] AND the guard of slot 0, because slot 0 is the only slot that may branch. For slots 1 to 3, br_reject[s] equals br_req[s]. br_reject[0] is always 0.
- R9: A predicate write whose slot guard is false changes no predicate.
- R10: sel_y[32s+31:32s] equals sel_a[32s+31:32s] when pred_q[sel_pidx[4s+3:4s]] is 1, and sel_b[32s+31:32s] otherwise, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pw_en | input | 4 | Per-slot request to write a predicate |
| pw_idx | input | 16 | Per-slot index of the predicate to write (4 bits per slot) |
| pw_val | input | 4 | Per-slot compare result to write |
| g_idx | input | 16 | Per-slot index of the guard predicate |
| g_inv | input | 4 | Per-slot guard invert bit |
| rf_we_raw | input | 4 | Raw register-write enables |
| st_en_raw | input | 4 | Raw store enables |
| br_req | input | 4 | Per-slot branch requests |
| sel_pidx | input | 16 | Per-slot predicate index used by the select |
| sel_a | input | 128 | Per-slot select operand taken when the predicate is true |
| sel_b | input | 128 | Per-slot select operand taken when the predicate is false |
| rf_we | output | 4 | Guarded register-write enables |
| st_en | output | 4 | Guarded store enables |
| br_take | output | 1 | Guarded branch from the designated slot |
| br_reject | output | 4 | Branch requests refused because they came from other slots |
| sel_y | output | 128 | Per-slot select results |
| pred_q | output | 16 | Current contents of the predicate file |

## Verification
The guarded enables, the branch outputs and the select results are combinational, so they are due in the same cycle as the inputs that produce them. The bench compares them a few nanoseconds after it drives those inputs on the falling edge. A predicate write is due one rising edge later. The bench compares pred_q just after that edge against a reference file that it updates only after it has checked the same-cycle outputs. This ordering catches a design that lets a write reach a guard too early, as well as one that stores it too late.

// File: rtl/pred_guard_unit.sv
module pred_guard_unit #(
  parameter int NSLOT   = 4,
  parameter int NPRED   = 16,
  parameter int DW      = 32,
  parameter int BR_SLOT = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       pw_en,
  input  logic [NSLOT*$clog2(NPRED)-1:0] pw_idx,
  input  logic [NSLOT-1:0]       pw_val,
  input  logic [NSLOT*$clog2(NPRED)-1:0] g_idx,
  input  logic [NSLOT-1:0]       g_inv,
  input  logic [NSLOT-1:0]       rf_we_raw,
  input  logic [NSLOT-1:0]       st_en_raw,
  input  logic [NSLOT-1:0]       br_req,
  input  logic [NSLOT*$clog2(NPRED)-1:0] sel_pidx,
  input  logic [NSLOT*DW-1:0]    sel_a,
  input  logic [NSLOT*DW-1:0]    sel_b,
  output logic [NSLOT-1:0]       rf_we,
  output logic [NSLOT-1:0]       st_en,
  output logic                   br_take,
  output logic [NSLOT-1:0]       br_reject,
  output logic [NSLOT*DW-1:0]    sel_y,
  output logic [NPRED-1:0]       pred_q
);
  localparam int PW = $clog2(NPRED);
  localparam logic [NSLOT-1:0] BR_MASK = NSLOT'(1) << BR_SLOT;

  logic [NPRED-1:0] pq;
  logic [NSLOT-1:0] grd;

  assign pred_q = pq;
  assign pq[0]  = 1'b1;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign grd[s] = pq[g_idx[s*PW +: PW]] ^ g_inv[s];
    assign sel_y[s*DW +: DW] = pq[sel_pidx[s*PW +: PW]] ? sel_a[s*DW +: DW]
                                                        : sel_b[s*DW +: DW];
  end

  assign rf_we     = rf_we_raw & grd;
  assign st_en     = st_en_raw & grd;
  assign br_take   = br_req[BR_SLOT] & grd[BR_SLOT];
  assign br_reject = br_req & ~BR_MASK;

  for (genvar p = 1; p < NPRED; p++) begin : g_pbit
    logic hit, d, q;
    always_comb begin
      hit = 1'b0;
      d   = q;
      for (int s = 0; s < NSLOT; s++) begin
        if (pw_en[s] && grd[s] && pw_idx[s*PW +: PW] == PW'(p)) begin
          hit = 1'b1;
          d   = pw_val[s];
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (hit) q <= d;
    end
    assign pq[p] = q;
  end
endmodule

module pred_guard_chk #(
  parameter int NSLOT   = 4,
  parameter int NPRED   = 16,
  parameter int DW      = 32,
  parameter int BR_SLOT = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NSLOT-1:0]       pw_en,
  input logic [NSLOT*$clog2(NPRED)-1:0] pw_idx,
  input logic [NSLOT-1:0]       pw_val,
  input logic [NSLOT*$clog2(NPRED)-1:0] g_idx,
  input logic [NSLOT-1:0]       g_inv,
  input logic [NSLOT-1:0]       rf_we_raw,
  input logic [NSLOT-1:0]       st_en_raw,
  input logic [NSLOT-1:0]       br_req,
  input logic [NSLOT*$clog2(NPRED)-1:0] sel_pidx,
  input logic [NSLOT*DW-1:0]    sel_a,
  input logic [NSLOT*DW-1:0]    sel_b,
  input logic [NSLOT-1:0]       rf_we,
  input logic [NSLOT-1:0]       st_en,
  input logic                   br_take,
  input logic [NSLOT-1:0]       br_reject,
  input logic [NSLOT*DW-1:0]    sel_y,
  input logic [NPRED-1:0]       pred_q
);
  localparam int PW = $clog2(NPRED);
  localparam int TOP = NSLOT - 1;

  logic top_g;
  assign top_g = pred_q[g_idx[TOP*PW +: PW]] ^ g_inv[TOP];

  // R2
  p0_true_chk: assert property (@(posedge clk) disable iff (!rst_n) pred_q[0]);

  // R4
  top_slot_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en[TOP] && top_g && pw_idx[TOP*PW +: PW] != '0)
    |=> pred_q[$past(pw_idx[TOP*PW +: PW])] == $past(pw_val[TOP]));

  // R8
  br_from_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |-> br_req[BR_SLOT]);

  // R10
  sel_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_y[DW-1:0] == (pred_q[sel_pidx[PW-1:0]] ? sel_a[DW-1:0] : sel_b[DW-1:0]));

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    // R6
    rf_we_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we[s] |-> (rf_we_raw[s] && (pred_q[g_idx[s*PW +: PW]] ^ g_inv[s])));
    // R7
    st_en_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_en[s] |-> (st_en_raw[s] && (pred_q[g_idx[s*PW +: PW]] ^ g_inv[s])));
    if (s != BR_SLOT) begin : g_rej
      // R8
      br_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_req[s] |-> br_reject[s]);
    end
  end
endmodule

bind pred_guard_unit pred_guard_chk #(
  .NSLOT(NSLOT), .NPRED(NPRED), .DW(DW), .BR_SLOT(BR_SLOT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pw_en(pw_en), .pw_idx(pw_idx), .pw_val(pw_val),
  .g_idx(g_idx), .g_inv(g_inv), .rf_we_raw(rf_we_raw), .st_en_raw(st_en_raw),
  .br_req(br_req), .sel_pidx(sel_pidx), .sel_a(sel_a), .sel_b(sel_b),
  .rf_we(rf_we), .st_en(st_en), .br_take(br_take), .br_reject(br_reject),
  .sel_y(sel_y), .pred_q(pred_q)
);

// File: tb/pred_guard_unit_tb.sv
module pred_guard_unit_tb_top;
  localparam int NS = 4, NP = 16, PW = 4, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] pw_en, pw_val, g_inv, rf_we_raw, st_en_raw, br_req;
  logic [NS*PW-1:0] pw_idx, g_idx, sel_pidx;
  logic [NS*DW-1:0] sel_a, sel_b, sel_y;
  logic [NS-1:0] rf_we, st_en, br_reject;
  logic br_take;
  logic [NP-1:0] pred_q;

  int n_chk = 0, n_fail = 0;
  bit ref_p [NP];
  bit done = 0;

  always #10 clk = ~clk;

  pred_guard_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pw_en(pw_en), .pw_idx(pw_idx), .pw_val(pw_val),
    .g_idx(g_idx), .g_inv(g_inv), .rf_we_raw(rf_we_raw), .st_en_raw(st_en_raw),
    .br_req(br_req), .sel_pidx(sel_pidx), .sel_a(sel_a), .sel_b(sel_b),
    .rf_we(rf_we), .st_en(st_en), .br_take(br_take), .br_reject(br_reject),
    .sel_y(sel_y), .pred_q(pred_q)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] ref_vec();
    logic [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = ref_p[i];
    return v;
  endfunction

  task automatic clear_in();
    pw_en = '0; pw_val = '0; g_inv = '0; rf_we_raw = '0; st_en_raw = '0;
    br_req = '0; pw_idx = '0; g_idx = '0; sel_pidx = '0;
    sel_a = '0; sel_b = '0;
  endtask

  task automatic set_slot_pw(int s, int idx, bit val, int gi, bit ginv);
    pw_en[s] = 1'b1; pw_idx[s*PW +: PW] = PW'(idx); pw_val[s] = val;
    g_idx[s*PW +: PW] = PW'(gi); g_inv[s] = ginv;
  endtask

  task automatic do_cycle();
    bit g [NS];
    bit nxt [NP];
    logic [NS-1:0] e_we, e_st, e_rej;
    #2;
    for (int s = 0; s < NS; s++) g[s] = ref_p[g_idx[s*PW +: PW]] ^ g_inv[s];
    for (int s = 0; s < NS; s++) begin
      e_we[s] = rf_we_raw[s] & g[s];
      e_st[s] = st_en_raw[s] & g[s];
      e_rej[s] = (s == 0) ? 1'b0 : br_req[s];
    end
    chk("R6", 64'(rf_we), 64'(e_we));
    chk("R7", 64'(st_en), 64'(e_st));
    chk("R8", 64'(br_take), 64'(br_req[0] & g[0]));
    chk("R8", 64'(br_reject), 64'(e_rej));
    for (int s = 0; s < NS; s++)
      chk("R10", 64'(sel_y[s*DW +: DW]),
          64'(ref_p[sel_pidx[s*PW +: PW]] ? sel_a[s*DW +: DW] : sel_b[s*DW +: DW]));
    nxt = ref_p;
    for (int s = 0; s < NS; s++)
      if (pw_en[s] && g[s] && pw_idx[s*PW +: PW] != 0) nxt[pw_idx[s*PW +: PW]] = pw_val[s];
    ref_p = nxt;
    @(posedge clk); #2;
    chk("R3", 64'(pred_q), 64'(ref_vec()));
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clear_in();
    for (int i = 0; i < NP; i++) ref_p[i] = (i == 0);
    repeat (3) @(negedge clk);
    chk("R1", 64'(pred_q), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'(pred_q), 64'h1);

    // R3: slot0 sets p3; slot1 guarded on p3 sees old value this cycle
    clear_in();
    set_slot_pw(0, 3, 1'b1, 0, 1'b0);
    g_idx[1*PW +: PW] = 4'd3; rf_we_raw[1] = 1'b1;
    do_cycle();
    chk("R3", 64'(pred_q[3]), 64'h1);

    // R2: write 0 to p0 is ignored
    clear_in();
    set_slot_pw(2, 0, 1'b0, 0, 1'b0);
    do_cycle();
    chk("R2", 64'(pred_q[0]), 64'h1);

    // R4: slots 1 and 3 write p5, slot 3 wins
    clear_in();
    set_slot_pw(1, 5, 1'b0, 0, 1'b0);
    set_slot_pw(3, 5, 1'b1, 0, 1'b0);
    do_cycle();
    chk("R4", 64'(pred_q[5]), 64'h1);
    clear_in();
    set_slot_pw(0, 5, 1'b1, 0, 1'b0);
    set_slot_pw(2, 5, 1'b0, 0, 1'b0);
    do_cycle();
    chk("R4", 64'(pred_q[5]), 64'h0);

    // R5: inverted guard on false p6 enables writes; on p0 disables
    clear_in();
    g_idx[2*PW +: PW] = 4'd6; g_inv[2] = 1'b1; rf_we_raw[2] = 1'b1;
    g_inv[1] = 1'b1; rf_we_raw[1] = 1'b1; st_en_raw[1] = 1'b1;
    #2;
    chk("R5", 64'(rf_we[2]), 64'h1);
    chk("R5", 64'(rf_we[1]), 64'h0);
    @(negedge clk);
    do_cycle();

    // R9: guard false blocks predicate write
    clear_in();
    set_slot_pw(1, 7, 1'b1, 0, 1'b1);
    do_cycle();
    chk("R9", 64'(pred_q[7]), 64'h0);

    // R8: branch on slot 0 and rejected branch on slot 2
    clear_in();
    br_req = 4'b0101;
    #2;
    chk("R8", 64'(br_take), 64'h1);
    chk("R8", 64'(br_reject), 64'h4);
    @(negedge clk);

    // R10: select by p3 (true) and p4 (false)
    clear_in();
    sel_a = {32'hAAAA0003, 32'hAAAA0002, 32'hAAAA0001, 32'hAAAA0000};
    sel_b = {32'hBBBB0003, 32'hBBBB0002, 32'hBBBB0001, 32'hBBBB0000};
    sel_pidx = {4'd4, 4'd3, 4'd0, 4'd4};
    do_cycle();

    for (int k = 0; k < 400; k++) begin
      pw_en = 4'($urandom); pw_val = 4'($urandom); g_inv = 4'($urandom);
      rf_we_raw = 4'($urandom); st_en_raw = 4'($urandom); br_req = 4'($urandom);
      pw_idx = 16'($urandom); g_idx = 16'($urandom); sel_pidx = 16'($urandom);
      for (int s = 0; s < NS; s++) begin
        sel_a[s*DW +: DW] = $urandom; sel_b[s*DW +: DW] = $urandom;
      end
      do_cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule